// File: doc/BRIEF.md
# Real-Time Clock Time Update Engine

This block holds the seconds, minutes and hours of a real-time clock and advances them by one second each time a one-hertz tick pulse arrives. The tick is a single-cycle pulse already synchronous to the block clock. An advance is carried out as an update cycle. The tick is captured in one clock, and the new time is applied in the next. Seconds roll over into minutes, and minutes roll over into hours. The cycle ends with a one-clock update-done pulse.

Two runtime controls select the number format. The first chooses between plain binary and packed BCD. The second chooses between a 24-hour clock and a 12-hour clock with a PM flag in the hour byte. A hold control freezes the clock so software can load the time. While hold is asserted, no tick is accepted, and an update that has been captured but not yet applied is dropped. Writes through the byte-wide write port take effect only while hold is asserted. The read port returns any time byte combinationally.

Top module: `rtc_tick_engine`

## Requirements
- R1: After reset the seconds, minutes and hours bytes read 0x00 and upd_done is low.
- R2: A tick_1hz pulse sampled while hold_set is low makes exactly one update. The new time becomes visible after the second rising edge counted from the edge that sampled the tick. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. A byte changes only when every lower byte wraps.
- R3: upd_done is high for exactly one clock, in the first cycle in which the updated time is visible, and it is never high otherwise.
- R4: While hold_set is high, ticks are ignored. If hold_set is high at the edge where a captured tick would be applied, that update is aborted: no byte changes and upd_done stays low.
- R5: When wr_en and hold_set are both high, wr_data is stored at the next edge into the byte chosen by wr_sel (0 seconds, 1 minutes, 2 hours). When hold_set is low, wr_en is ignored.
- R6: rd_data shows the byte chosen by rd_sel (0 seconds, 1 minutes, 2 hours) without delay. A rd_sel of 3 returns 0x00.
- R7: With fmt_bin low, each byte is packed BCD: tens in bits 7:4 and units in bits 3:0. A units digit of 9 wraps to 0 and carries into the tens digit (0x09 becomes 0x10, 0x59 becomes 0x00).
- R8: With fmt_bin high, the bytes are plain binary and count by ordinary increment: 0x3B (59) wraps to 0x00, and a 24-hour value of 0x17 (23) wraps to 0x00.
- R9: With fmt_24h high, the hour counts 0 to 23 and then wraps to 0 (BCD 0x23 becomes 0x00).
- R10: With fmt_24h low, hour bit 7 is the PM flag (0 AM, 1 PM) and bits 6:0 hold 1 to 12. The hour advances 12, 1, 2 … 11. Going from 11 to 12 toggles PM, and going from 12 to 1 keeps PM. 12 AM is midnight, so PM 11 becomes 0x12 in BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| hold_set | input | 1 | Freeze the time and enable writes |
| fmt_bin | input | 1 | 1 selects binary, 0 selects packed BCD |
| fmt_24h | input | 1 | 1 selects 24-hour, 0 selects 12-hour with PM flag |
| wr_en | input | 1 | Write strobe for a time byte |
| wr_sel | input | 2 | Byte selected for writing |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Byte selected for reading |
| rd_data | output | 8 | Read data |
| upd_done | output | 1 | One-cycle pulse at the end of each update |

## Verification
The two functions that can fall in the same cycle are a captured tick waiting to be applied and the rise of hold_set. The bench raises hold_set in the clock right after the tick is sampled, so the apply edge sees hold high. It then judges that the seconds byte is unchanged and that upd_done stayed low. The bench also issues a byte write while hold is asserted in that window and checks that the written value survives with no counter increment on top of it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned NUM_W    = 7;
   localparam int unsigned FLD_SEC  = 0;
   localparam int unsigned FLD_MIN  = 1;
   localparam int unsigned FLD_HR   = 2;
   localparam int unsigned NUM_FLD  = 3;

   // Decode a stored byte into its numeric value (0..99 range used).
   function automatic logic [NUM_W-1:0] byte_to_num(input logic [BYTE_W-1:0] b,
                                                    input logic bin);
      logic [BYTE_W-1:0] t;
      if (bin) t = {1'b0, b[6:0]};
      else     t = ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
      return t[NUM_W-1:0];
   endfunction

   // Encode a numeric value into binary or packed BCD.
   function automatic logic [BYTE_W-1:0] num_to_byte(input logic [NUM_W-1:0] n,
                                                     input logic bin);
      logic [NUM_W-1:0] tq;
      logic [NUM_W-1:0] on;
      tq = n / 7'd10;
      on = n - (tq * 7'd10);
      if (bin) return {1'b0, n};
      else     return {tq[3:0], on[3:0]};
   endfunction

endpackage

// File: rtl/rtc_field_inc.sv
module rtc_field_inc
   import rtc_pkg::*;
#(
   parameter int unsigned TOP_VAL = 59
) (
   input  logic [BYTE_W-1:0] cur,
   input  logic              bin,
   output logic [BYTE_W-1:0] nxt,
   output logic              wrap
);

   if (TOP_VAL < 1 || TOP_VAL > 99) begin : g_bad_top
      $error("rtc_field_inc: TOP_VAL out of range");
   end

   logic [NUM_W-1:0] num;

   always_comb begin
      num  = byte_to_num(cur, bin);
      wrap = (num >= NUM_W'(TOP_VAL));
      if (wrap) nxt = num_to_byte('0, bin);
      else      nxt = num_to_byte(num + 7'd1, bin);
   end

endmodule

// File: rtl/rtc_hour_inc.sv
module rtc_hour_inc
   import rtc_pkg::*;
#(
   parameter int unsigned TOP_24 = 23,
   parameter int unsigned TOP_12 = 12
) (
   input  logic [BYTE_W-1:0] cur,
   input  logic              bin,
   input  logic              h24,
   output logic [BYTE_W-1:0] nxt
);

   if (TOP_24 > 99 || TOP_12 > 99 || TOP_12 < 2) begin : g_bad_top
      $error("rtc_hour_inc: hour limits out of range");
   end

   logic [NUM_W-1:0]  n24, n12, h12;
   logic              pm_nxt;
   logic [BYTE_W-1:0] enc12;

   always_comb begin
      n24    = byte_to_num(cur, bin);
      n12    = byte_to_num({1'b0, cur[6:0]}, bin);
      pm_nxt = cur[7];
      if (n12 >= NUM_W'(TOP_12)) begin
         h12 = 7'd1;
      end else if (n12 == NUM_W'(TOP_12 - 1)) begin
         h12    = NUM_W'(TOP_12);
         pm_nxt = ~cur[7];
      end else begin
         h12 = n12 + 7'd1;
      end
      enc12 = num_to_byte(h12, bin);
      if (h24) begin
         if (n24 >= NUM_W'(TOP_24)) nxt = num_to_byte('0, bin);
         else                       nxt = num_to_byte(n24 + 7'd1, bin);
      end else begin
         nxt = {pm_nxt, enc12[6:0]};
      end
   end

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   output logic apply,
   output logic done
);

   logic pend_q;

   assign apply = pend_q & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         pend_q <= tick & ~hold;
         done   <= apply;
      end
   end

endmodule

// File: rtl/rtc_tick_engine.sv
module rtc_tick_engine
   import rtc_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned SEC_TOP = 59,
   parameter int unsigned MIN_TOP = 59,
   parameter int unsigned HR_TOP  = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              hold_set,
   input  logic              fmt_bin,
   input  logic              fmt_24h,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              upd_done
);

   localparam int unsigned NUM_LOW = NUM_FLD - 1;

   if (DATA_W != BYTE_W) begin : g_bad_w
      $error("rtc_tick_engine: DATA_W must be 8");
   end
   if ((1 << SEL_W) < NUM_FLD) begin : g_bad_sel
      $error("rtc_tick_engine: SEL_W too narrow");
   end

   logic [DATA_W-1:0] fld_q   [NUM_FLD];
   logic [DATA_W-1:0] fld_nxt [NUM_FLD];
   logic [NUM_FLD-1:0] adv;
   logic [NUM_LOW-1:0] wrap;
   logic              apply;

   rtc_update_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_1hz),
      .hold  (hold_set),
      .apply (apply),
      .done  (upd_done)
   );

   for (genvar g = 0; g < NUM_LOW; g++) begin : g_low
      localparam int unsigned TOP = (g == FLD_SEC) ? SEC_TOP : MIN_TOP;
      rtc_field_inc #(.TOP_VAL(TOP)) u_inc (
         .cur  (fld_q[g]),
         .bin  (fmt_bin),
         .nxt  (fld_nxt[g]),
         .wrap (wrap[g])
      );
   end

   rtc_hour_inc #(.TOP_24(HR_TOP), .TOP_12(12)) u_hr (
      .cur (fld_q[FLD_HR]),
      .bin (fmt_bin),
      .h24 (fmt_24h),
      .nxt (fld_nxt[FLD_HR])
   );

   always_comb begin
      adv[0] = apply;
      for (int i = 1; i < NUM_FLD; i++) adv[i] = adv[i-1] & wrap[i-1];
   end

   for (genvar g = 0; g < NUM_FLD; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                            fld_q[g] <= '0;
         else if (hold_set && wr_en && (wr_sel == SEL_W'(g)))   fld_q[g] <= wr_data;
         else if (adv[g])                                       fld_q[g] <= fld_nxt[g];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_FLD; i++)
         if (rd_sel == SEL_W'(i)) rd_data = fld_q[i];
   end

   logic [DATA_W-1:0] sec_w, min_w, hr_w;
   assign sec_w = fld_q[FLD_SEC];
   assign min_w = fld_q[FLD_MIN];
   assign hr_w  = fld_q[FLD_HR];

endmodule

// File: rtl/rtc_tick_engine_chk.sv
module rtc_tick_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_1hz,
   input logic       hold_set,
   input logic       fmt_bin,
   input logic       wr_en,
   input logic [1:0] wr_sel,
   input logic [7:0] wr_data,
   input logic       upd_done,
   input logic [7:0] sec_w,
   input logic [7:0] min_w
);

   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |=> !upd_done);

   p_done_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> ($past(tick_1hz, 2) && !$past(hold_set)));

   p_hold_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_set) |-> !upd_done);

   p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_set && !wr_en) |=> ($stable(sec_w) && $stable(min_w)));

   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_set && wr_en && wr_sel == 2'd0) |=> (sec_w == $past(wr_data)));

   p_bin_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_done && fmt_bin && $past(fmt_bin)) |-> (sec_w <= 8'd59));

endmodule

bind rtc_tick_engine rtc_tick_engine_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_1hz (tick_1hz),
   .hold_set (hold_set),
   .fmt_bin  (fmt_bin),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .upd_done (upd_done),
   .sec_w    (sec_w),
   .min_w    (min_w)
);

// File: tb/test_rtc_tick_engine.sv
module test_rtc_tick_engine;

   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 14;

   // {bin, h24, hr, min, sec, exp_hr, exp_min, exp_sec}
   localparam logic [49:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01},
      {1'b0, 1'b1, 8'h00, 8'h00, 8'h09, 8'h00, 8'h00, 8'h10},
      {1'b0, 1'b1, 8'h00, 8'h00, 8'h59, 8'h00, 8'h01, 8'h00},
      {1'b0, 1'b1, 8'h12, 8'h59, 8'h59, 8'h13, 8'h00, 8'h00},
      {1'b0, 1'b1, 8'h23, 8'h59, 8'h59, 8'h00, 8'h00, 8'h00},
      {1'b1, 1'b1, 8'h17, 8'h3B, 8'h3B, 8'h00, 8'h00, 8'h00},
      {1'b1, 1'b1, 8'h09, 8'h3B, 8'h3B, 8'h0A, 8'h00, 8'h00},
      {1'b0, 1'b0, 8'h11, 8'h59, 8'h59, 8'h92, 8'h00, 8'h00},
      {1'b0, 1'b0, 8'h92, 8'h59, 8'h59, 8'h81, 8'h00, 8'h00},
      {1'b0, 1'b0, 8'h91, 8'h59, 8'h59, 8'h12, 8'h00, 8'h00},
      {1'b1, 1'b0, 8'h0B, 8'h3B, 8'h3B, 8'h8C, 8'h00, 8'h00},
      {1'b1, 1'b0, 8'h8C, 8'h3B, 8'h3B, 8'h81, 8'h00, 8'h00},
      {1'b0, 1'b0, 8'h09, 8'h59, 8'h59, 8'h10, 8'h00, 8'h00},
      {1'b0, 1'b0, 8'h05, 8'h10, 8'h59, 8'h05, 8'h11, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0, hold_set = 1'b0, fmt_bin = 1'b0, fmt_24h = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0, rd_sel = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       upd_done;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_tick_engine i_rtc_tick_engine (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .hold_set(hold_set),
      .fmt_bin(fmt_bin), .fmt_24h(fmt_24h), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .upd_done(upd_done)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] sel, output logic [7:0] val);
      rd_sel = sel;
      #1;
      val = rd_data;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Returns at the negedge where the update result is visible.
   task automatic tick_pulse();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
   endtask

   task automatic load(input logic b, input logic h, input logic [7:0] hr,
                       input logic [7:0] mn, input logic [7:0] sc);
      @(negedge clk);
      hold_set = 1'b1; fmt_bin = b; fmt_24h = h;
      wr(2'd0, sc); wr(2'd1, mn); wr(2'd2, hr);
      @(negedge clk);
      hold_set = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, v); check(v, 8'h00, "R1 sec reset");
      rd(2'd1, v); check(v, 8'h00, "R1 min reset");
      rd(2'd2, v); check(v, 8'h00, "R1 hr reset");
      check({7'd0, upd_done}, 8'h00, "R1 done reset");
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: R2 R7 R8 R9 R10 and R3
      for (int i = 0; i < NVEC; i++) begin
         load(VEC[i][49], VEC[i][48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
         tick_pulse();
         check({7'd0, upd_done}, 8'h01, $sformatf("R3 done vec%0d", i));
         rd(2'd2, v); check(v, VEC[i][23:16], $sformatf("R2/R9/R10 hr vec%0d", i));
         rd(2'd1, v); check(v, VEC[i][15:8],  $sformatf("R2/R7/R8 min vec%0d", i));
         rd(2'd0, v); check(v, VEC[i][7:0],   $sformatf("R2/R7/R8 sec vec%0d", i));
         @(negedge clk);
         check({7'd0, upd_done}, 8'h00, $sformatf("R3 done width vec%0d", i));
      end

      // R2/R7: twelve ticks in BCD from zero reach 0x12, one step per tick
      load(1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
      for (int k = 0; k < 12; k++) begin
         tick_pulse();
         repeat (2) @(negedge clk);
      end
      rd(2'd0, v); check(v, 8'h12, "R2 R7 twelve ticks");

      // R4: ticks ignored while hold is high
      @(negedge clk); hold_set = 1'b1;
      tick_pulse();
      check({7'd0, upd_done}, 8'h00, "R4 hold no done");
      rd(2'd0, v); check(v, 8'h12, "R4 hold no count");

      // R4: abort of a captured tick, with a write landing in the same window (R5)
      hold_set = 1'b0;
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0; hold_set = 1'b1;
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h44;
      @(negedge clk); wr_en = 1'b0;
      check({7'd0, upd_done}, 8'h00, "R4 abort no done");
      rd(2'd0, v); check(v, 8'h12, "R4 abort sec unchanged");
      rd(2'd1, v); check(v, 8'h44, "R5 write in abort window");
      @(negedge clk);
      check({7'd0, upd_done}, 8'h00, "R4 abort no late done");

      // R5: write ignored while hold is low
      hold_set = 1'b0;
      wr(2'd0, 8'h33);
      rd(2'd0, v); check(v, 8'h12, "R5 write ignored");

      // R6: unused select reads zero
      rd(2'd3, v); check(v, 8'h00, "R6 sel3 zero");

      // R1: reset mid-run clears everything
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      rd(2'd1, v); check(v, 8'h00, "R1 reset clears min");
      rst_n = 1'b1;

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule